// File: doc/BRIEF.md
# Dual-Channel Serial Register Front End

This block is the host side of a two-channel asynchronous serial controller. The host sees only two byte-wide ports per channel, a control port and a data port. Each channel holds sixteen write registers and a set of read registers. These are reached indirectly through a per-channel pointer. A control write to register 0 loads the pointer, and the pointer falls back to 0 once the selected register has been accessed.

The block holds the write register files and the status registers, and it applies the reset defaults. A single write can reset either channel or both. From the mode registers it derives the character format (data length, parity, stop bits) and the total divide ratio. An external baud generator and shifter consume these values. The shifter reports back through three pulses: a byte was received, a byte was taken for transmission, and a byte is to be sent. Every register access completes in one clock. Read data is registered and appears on the cycle after the read strobe.

Top module: `sio_regfront`

## Requirements
- R1: Address bit STRIDE selects the port, 0 for control and 1 for data. Bit STRIDE+1 selects the channel, 0 for channel index 0 ("B") and 1 for channel index 1 ("A"). Address bits below STRIDE are ignored. A read strobe raised together with a write strobe is ignored.
- R2: While a channel's pointer is 0, a control write loads the pointer from data bits 2:0. The command field is data bits 5:3, and when it equals 3'b001 (byte value 0x08 in that field) it also sets pointer bit 3. Any other command value leaves bit 3 at 0.
- R3: A control write while the pointer is non-zero writes the selected register and returns the pointer to 0. Any control read returns the selected read register and returns the pointer to 0.
- R4: A write to register 9 with bits 7:6 = 01 resets channel index 0, 10 resets channel index 1, and 11 resets both. When that field is non-zero, register 9 itself is not updated. A value of 00 resets nothing.
- R5: After reset, read register 0 (status) is 0x44, or 0x7C when parameter DISABLED is 1. Read register 1 is 0x07 and read registers 12 and 13 are 0. The format is 5 data bits, no parity and one stop bit, with a x1 multiplier and a divisor of 2.
- R6: In register 4, bit 0 enables parity and bit 1 selects even parity. Two stop bits are selected only when bits 3:2 = 11. Bits 7:6 select a clock multiplier of 1, 16, 32 or 64 for codes 00 to 11.
- R7: Register 5 bits 6:5 give the data length: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8.
- R8: The divisor output equals (time constant + 2) times the multiplier. The time constant is {register 13, register 12}. Writes to registers 12 and 13 are readable at read registers 12 and 13.
- R9: A data write sets status bit 2 and read register 1 bit 0. It pulses tx_strobe with the byte when register 5 bit 3 is set. A tx_taken pulse clears both bits, and a data write in the same cycle wins.
- R10: An rx_load pulse latches the byte and sets status bit 0. A data read returns the latched byte and clears status bit 0 unless rx_load arrives in the same cycle.
- R11: Read data appears on rd_data one clock after the read strobe and holds until the next read. Read registers other than 0, 1, 12 and 13 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| bus_addr | input | STRIDE+2 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rx_load | input | 2 | Per channel: received byte available |
| rx_byte | input | 16 | Per channel received byte, channel i at [8i+7:8i] |
| tx_taken | input | 2 | Per channel: shifter took the byte |
| tx_strobe | output | 2 | Per channel: byte to transmit |
| tx_byte | output | 8 | Byte accompanying tx_strobe |
| cfg_data_bits | output | 8 | Per channel data length (5..8), 4 bits each |
| cfg_par_en | output | 2 | Per channel parity enable |
| cfg_par_even | output | 2 | Per channel even parity |
| cfg_two_stop | output | 2 | Per channel two stop bits |
| cfg_clk_mult | output | 14 | Per channel clock multiplier, 7 bits each |
| cfg_divisor | output | 46 | Per channel total divide ratio, 23 bits each |

## Verification
The bench builds the block with STRIDE = 1, so the whole address space is 3 bits and every port of both channels, as well as the ignored low bit, can be driven directly. A second copy with DISABLED = 1 shares the bus so that both status reset values can be seen. With this small configuration, all 256 values of register 4 and all four data-length codes can be swept on both channels. A set of time constants that includes 0 and 0xFFFF is combined with every multiplier, and each result is compared against the divisor formula computed in the bench.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int NCH    = 2;
  localparam int NREG   = 16;
  localparam int PTR_W  = $clog2(NREG);
  localparam int TC_W   = 16;
  localparam int MUL_W  = 7;
  localparam int DIV_W  = TC_W + MUL_W;
  localparam int DBW    = 4;

  localparam logic [3:0] IX_FMT   = 4'd4;
  localparam logic [3:0] IX_TXC   = 4'd5;
  localparam logic [3:0] IX_MRST  = 4'd9;
  localparam logic [3:0] IX_CLKS  = 4'd11;
  localparam logic [3:0] IX_TCLO  = 4'd12;
  localparam logic [3:0] IX_TCHI  = 4'd13;
  localparam logic [3:0] IX_MISC  = 4'd14;
  localparam logic [3:0] IX_XIE   = 4'd15;

  localparam logic [7:0] DEF_FMT  = 8'h04;
  localparam logic [7:0] DEF_MRST = 8'hC0;
  localparam logic [7:0] DEF_CLKS = 8'h08;
  localparam logic [7:0] DEF_MISC = 8'h30;
  localparam logic [7:0] DEF_XIE  = 8'hF8;
  localparam logic [7:0] DEF_STAT = 8'h44;
  localparam logic [7:0] DEF_STOFF= 8'h7C;
  localparam logic [7:0] DEF_SPEC = 8'h07;

  function automatic logic [DBW-1:0] f_data_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd5;
      2'b01:   return 4'd7;
      2'b10:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [MUL_W-1:0] f_clk_mult(input logic [1:0] code);
    case (code)
      2'b00:   return 7'd1;
      2'b01:   return 7'd16;
      2'b10:   return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] f_divisor(input logic [TC_W-1:0] tc,
                                                 input logic [MUL_W-1:0] mul);
    logic [DIV_W-1:0] base;
    base = DIV_W'(tc) + DIV_W'(2);
    return base * DIV_W'(mul);
  endfunction
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
  parameter int STRIDE = 0,
  parameter int AW     = STRIDE + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic                      wr,
  input  logic                      rd,
  output logic [sio_pkg::NCH-1:0]   ctrl_wr,
  output logic [sio_pkg::NCH-1:0]   ctrl_rd,
  output logic [sio_pkg::NCH-1:0]   data_wr,
  output logic [sio_pkg::NCH-1:0]   data_rd,
  output logic                      chan_sel,
  output logic                      rd_ok
);
  localparam int PORT_BIT = STRIDE;
  localparam int CHAN_BIT = STRIDE + 1;

  logic is_data;
  assign is_data  = addr[PORT_BIT];
  assign chan_sel = addr[CHAN_BIT];
  assign rd_ok    = rd && !wr;

  for (genvar c = 0; c < sio_pkg::NCH; c++) begin : g_sel
    logic hit;
    assign hit        = (chan_sel == 1'(c));
    assign ctrl_wr[c] = hit && wr && !is_data;
    assign data_wr[c] = hit && wr &&  is_data;
    assign ctrl_rd[c] = hit && rd_ok && !is_data;
    assign data_rd[c] = hit && rd_ok &&  is_data;
  end

  p_one_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, ctrl_rd, data_wr, data_rd}));
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs #(
  parameter bit DISABLED = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic                         ctrl_wr,
  input  logic                         ctrl_rd,
  input  logic                         data_wr,
  input  logic                         data_rd,
  input  logic [7:0]                   wdata,
  input  logic                         rx_load,
  input  logic [7:0]                   rx_byte,
  input  logic                         tx_taken,
  output logic [7:0]                   rdata,
  output logic [1:0]                   mrst_req,
  output logic                         tx_strobe,
  output logic [sio_pkg::DBW-1:0]      cfg_data_bits,
  output logic                         cfg_par_en,
  output logic                         cfg_par_even,
  output logic                         cfg_two_stop,
  output logic [sio_pkg::MUL_W-1:0]    cfg_clk_mult,
  output logic [sio_pkg::DIV_W-1:0]    cfg_divisor
);
  import sio_pkg::*;

  localparam logic [7:0] STAT_RST = DISABLED ? DEF_STOFF : DEF_STAT;
  localparam int B_RXAV = 0;
  localparam int B_TXE  = 2;
  localparam int B_SENT = 0;

  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       wreg_q [NREG];
  logic [7:0]       stat_q;
  logic [7:0]       spec_q;
  logic [7:0]       rxbuf_q;

  logic             at_base;
  logic [2:0]       cmd_code;
  logic             hi_bank;
  logic [PTR_W-1:0] ptr_load;
  logic             mrst_hit;
  logic             reg_store;

  assign at_base   = (ptr_q == '0);
  assign cmd_code  = wdata[5:3];
  assign hi_bank   = (cmd_code == 3'b001);
  assign ptr_load  = {hi_bank, wdata[2:0]};
  assign mrst_hit  = ctrl_wr && (ptr_q == IX_MRST);
  assign mrst_req  = mrst_hit ? wdata[7:6] : 2'b00;
  assign reg_store = ctrl_wr && !at_base && !(mrst_hit && (wdata[7:6] != 2'b00));

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ptr_q   <= '0;
      for (int i = 0; i < NREG; i++) wreg_q[i] <= 8'h00;
      wreg_q[IX_FMT]  <= DEF_FMT;
      wreg_q[IX_MRST] <= DEF_MRST;
      wreg_q[IX_CLKS] <= DEF_CLKS;
      wreg_q[IX_MISC] <= DEF_MISC;
      wreg_q[IX_XIE]  <= DEF_XIE;
      stat_q  <= STAT_RST;
      spec_q  <= DEF_SPEC;
      rxbuf_q <= 8'h00;
    end else begin
      if (ctrl_wr) begin
        ptr_q <= at_base ? ptr_load : '0;
      end else if (ctrl_rd) begin
        ptr_q <= '0;
      end
      if (reg_store) wreg_q[ptr_q] <= wdata;

      if (rx_load) begin
        stat_q[B_RXAV] <= 1'b1;
        rxbuf_q        <= rx_byte;
      end else if (data_rd) begin
        stat_q[B_RXAV] <= 1'b0;
      end

      if (data_wr) begin
        stat_q[B_TXE]  <= 1'b1;
        spec_q[B_SENT] <= 1'b1;
      end else if (tx_taken) begin
        stat_q[B_TXE]  <= 1'b0;
        spec_q[B_SENT] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (data_rd) begin
      rdata = rxbuf_q;
    end else begin
      case (ptr_q)
        4'd0:    rdata = stat_q;
        4'd1:    rdata = spec_q;
        IX_TCLO: rdata = wreg_q[IX_TCLO];
        IX_TCHI: rdata = wreg_q[IX_TCHI];
        default: rdata = 8'h00;
      endcase
    end
  end

  logic [TC_W-1:0] tconst;
  assign tconst        = {wreg_q[IX_TCHI], wreg_q[IX_TCLO]};
  assign tx_strobe     = data_wr && wreg_q[IX_TXC][3];
  assign cfg_par_en    = wreg_q[IX_FMT][0];
  assign cfg_par_even  = wreg_q[IX_FMT][1];
  assign cfg_two_stop  = (wreg_q[IX_FMT][3:2] == 2'b11);
  assign cfg_clk_mult  = f_clk_mult(wreg_q[IX_FMT][7:6]);
  assign cfg_data_bits = f_data_bits(wreg_q[IX_TXC][6:5]);
  assign cfg_divisor   = f_divisor(tconst, cfg_clk_mult);

  p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && at_base && !soft_rst |=> ptr_q == {$past(wdata[5:3]) == 3'b001, $past(wdata[2:0])});
  p_ptr_clear_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !at_base |=> ptr_q == '0);
  p_ptr_clear_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> ptr_q == '0);
  p_reset_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> cfg_divisor == DIV_W'(2) && !cfg_par_en && cfg_data_bits == 4'd5);
  p_tx_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> stat_q[B_TXE] && spec_q[B_SENT]);
  p_rx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !rx_load && !soft_rst |=> !stat_q[B_RXAV]);
  p_rx_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load && !soft_rst |=> stat_q[B_RXAV]);
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront #(
  parameter int STRIDE   = 0,
  parameter bit DISABLED = 1'b0,
  parameter int AW       = STRIDE + 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [AW-1:0]                          bus_addr,
  input  logic                                   bus_wr,
  input  logic                                   bus_rd,
  input  logic [7:0]                             bus_wdata,
  output logic [7:0]                             rd_data,
  input  logic [sio_pkg::NCH-1:0]                rx_load,
  input  logic [sio_pkg::NCH*8-1:0]              rx_byte,
  input  logic [sio_pkg::NCH-1:0]                tx_taken,
  output logic [sio_pkg::NCH-1:0]                tx_strobe,
  output logic [7:0]                             tx_byte,
  output logic [sio_pkg::NCH*sio_pkg::DBW-1:0]   cfg_data_bits,
  output logic [sio_pkg::NCH-1:0]                cfg_par_en,
  output logic [sio_pkg::NCH-1:0]                cfg_par_even,
  output logic [sio_pkg::NCH-1:0]                cfg_two_stop,
  output logic [sio_pkg::NCH*sio_pkg::MUL_W-1:0] cfg_clk_mult,
  output logic [sio_pkg::NCH*sio_pkg::DIV_W-1:0] cfg_divisor
);
  import sio_pkg::*;

  logic [NCH-1:0] ctrl_wr, ctrl_rd, data_wr, data_rd;
  logic           chan_sel, rd_ok;
  logic [7:0]     ch_rdata [NCH];
  logic [1:0]     ch_mrst  [NCH];
  logic [NCH-1:0] soft_rst;

  sio_addr_dec #(.STRIDE(STRIDE), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .data_wr(data_wr), .data_rd(data_rd),
    .chan_sel(chan_sel), .rd_ok(rd_ok)
  );

  // Reset field bit i targets channel index i, whichever channel carries the write.
  always_comb begin
    soft_rst = '0;
    for (int c = 0; c < NCH; c++) soft_rst = soft_rst | ch_mrst[c];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_chan_regs #(.DISABLED(DISABLED)) u_ch (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst[c]),
      .ctrl_wr(ctrl_wr[c]), .ctrl_rd(ctrl_rd[c]),
      .data_wr(data_wr[c]), .data_rd(data_rd[c]),
      .wdata(bus_wdata),
      .rx_load(rx_load[c]), .rx_byte(rx_byte[c*8 +: 8]),
      .tx_taken(tx_taken[c]),
      .rdata(ch_rdata[c]), .mrst_req(ch_mrst[c]),
      .tx_strobe(tx_strobe[c]),
      .cfg_data_bits(cfg_data_bits[c*DBW +: DBW]),
      .cfg_par_en(cfg_par_en[c]), .cfg_par_even(cfg_par_even[c]),
      .cfg_two_stop(cfg_two_stop[c]),
      .cfg_clk_mult(cfg_clk_mult[c*MUL_W +: MUL_W]),
      .cfg_divisor(cfg_divisor[c*DIV_W +: DIV_W])
    );
  end

  assign tx_byte = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_ok) rd_data <= ch_rdata[chan_sel];
  end

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(rd_data));
  p_both_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst == 2'b11) |=> cfg_divisor == {DIV_W'(2), DIV_W'(2)});
endmodule

// File: tb/sio_regfront_tb.sv
module sio_regfront_tb;
  localparam int STRIDE = 1;
  localparam int AW     = STRIDE + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [1:0] rx_load = 2'b00, tx_taken = 2'b00;
  logic [15:0] rx_byte = 16'h0;
  logic [7:0] rd_data, rd_data_off, tx_byte, tx_byte_off;
  logic [1:0] tx_strobe, par_en, par_even, two_stop;
  logic [1:0] tx_strobe_off, par_en_off, par_even_off, two_stop_off;
  logic [7:0] dbits, dbits_off;
  logic [13:0] mult, mult_off;
  logic [45:0] divr, divr_off;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  sio_regfront #(.STRIDE(STRIDE), .DISABLED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .rd_data(rd_data), .rx_load(rx_load), .rx_byte(rx_byte), .tx_taken(tx_taken),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .cfg_data_bits(dbits), .cfg_par_en(par_en),
    .cfg_par_even(par_even), .cfg_two_stop(two_stop), .cfg_clk_mult(mult), .cfg_divisor(divr));

  sio_regfront #(.STRIDE(STRIDE), .DISABLED(1'b1)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .rd_data(rd_data_off), .rx_load(rx_load), .rx_byte(rx_byte), .tx_taken(tx_taken),
    .tx_strobe(tx_strobe_off), .tx_byte(tx_byte_off), .cfg_data_bits(dbits_off),
    .cfg_par_en(par_en_off), .cfg_par_even(par_even_off), .cfg_two_stop(two_stop_off),
    .cfg_clk_mult(mult_off), .cfg_divisor(divr_off));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ca(input int ch);
    return AW'(ch << (STRIDE + 1));
  endfunction
  function automatic logic [AW-1:0] da(input int ch);
    return ca(ch) | AW'(1 << STRIDE);
  endfunction

  task automatic acc(input logic [AW-1:0] a, input bit w, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = w; rd = !w; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic set_ptr(input int ch, input int idx);
    acc(ca(ch), 1'b1, 8'((idx & 7) | ((idx >= 8) ? 8 : 0)));
  endtask

  task automatic wreg(input int ch, input int idx, input logic [7:0] v);
    if (idx != 0) set_ptr(ch, idx);
    acc(ca(ch), 1'b1, v);
  endtask

  task automatic rreg(input int ch, input int idx, output logic [7:0] v);
    if (idx != 0) set_ptr(ch, idx);
    acc(ca(ch), 1'b0, 8'h00);
    v = rd_data;
  endtask

  function automatic int exp_mult(input int code);
    return (code == 0) ? 1 : (8 << code);
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: reset values on both channels
    for (int ch = 0; ch < 2; ch++) begin
      rreg(ch, 0, v); chk("R5 status", 32'(v), 32'h44);
      chk("R5 status disabled", 32'(rd_data_off), 32'h7C);
      rreg(ch, 1, v); chk("R5 special", 32'(v), 32'h07);
      rreg(ch, 12, v); chk("R5 tc lo", 32'(v), 32'h00);
      chk("R5 data bits", 32'(dbits[ch*4 +: 4]), 32'd5);
      chk("R5 parity", 32'({par_en[ch], par_even[ch], two_stop[ch]}), 32'd0);
      chk("R5 divisor", 32'(divr[ch*23 +: 23]), 32'd2);
    end

    // R6: sweep of every register 4 value on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int val = 0; val < 256; val++) begin
        wreg(ch, 4, 8'(val));
        chk("R6 par_en", 32'(par_en[ch]), 32'(val & 1));
        chk("R6 par_even", 32'(par_even[ch]), 32'((val >> 1) & 1));
        chk("R6 two_stop", 32'(two_stop[ch]), 32'(((val >> 2) & 3) == 3));
        chk("R6 mult", 32'(mult[ch*7 +: 7]), 32'(exp_mult(val >> 6)));
      end
    end

    // R7: data length codes
    for (int ch = 0; ch < 2; ch++) begin
      for (int code = 0; code < 4; code++) begin
        wreg(ch, 5, 8'(code << 5));
        chk("R7 data bits", 32'(dbits[ch*4 +: 4]),
            32'(5 + ((code & 1) * 2) + ((code >> 1) & 1)));
      end
    end

    // R8: time constant and divisor
    begin
      int tcs [6] = '{0, 1, 255, 256, 16'h1234, 16'hFFFF};
      for (int ch = 0; ch < 2; ch++) begin
        foreach (tcs[k]) begin
          wreg(ch, 12, 8'(tcs[k]));
          wreg(ch, 13, 8'(tcs[k] >> 8));
          rreg(ch, 12, v); chk("R8 mirror lo", 32'(v), 32'(tcs[k] & 255));
          rreg(ch, 13, v); chk("R8 mirror hi", 32'(v), 32'(tcs[k] >> 8));
          for (int code = 0; code < 4; code++) begin
            wreg(ch, 4, 8'(code << 6));
            chk("R8 divisor", 32'(divr[ch*23 +: 23]), 32'((tcs[k] + 2) * exp_mult(code)));
          end
        end
      end
    end

    // R3: pointer returns to 0 after a register write
    wreg(0, 12, 8'h34);
    wreg(0, 5, 8'h60);
    chk("R3 write clears pointer", 32'(dbits[3:0]), 32'd8);
    rreg(0, 12, v); chk("R3 reg12 untouched", 32'(v), 32'h34);
    // R3: a control read clears the pointer
    set_ptr(0, 1);
    acc(ca(0), 1'b0, 8'h00); chk("R3 read selected", 32'(rd_data), 32'h07);
    acc(ca(0), 1'b0, 8'h00); chk("R3 read clears pointer", 32'(rd_data), 32'h44);

    // R2: a command code other than 001 does not set the high pointer bit
    acc(ca(1), 1'b1, 8'h15);
    acc(ca(1), 1'b1, 8'h40);
    chk("R2 low bank only", 32'(dbits[7:4]), 32'd6);

    // R1: low address bit ignored, channels independent
    acc(ca(1) | AW'(1), 1'b1, 8'h05);
    acc(ca(1) | AW'(1), 1'b1, 8'h20);
    chk("R1 low bit ignored", 32'(dbits[7:4]), 32'd7);
    chk("R1 other channel untouched", 32'(dbits[3:0]), 32'd8);
    // R1: read raised with write is ignored
    rreg(0, 12, v);
    @(negedge clk); addr = ca(0); wr = 1'b1; rd = 1'b1; wdata = 8'h00;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    chk("R1 read with write ignored", 32'(rd_data), 32'h34);

    // R11: unlisted read registers return 0
    wreg(0, 7, 8'hFF);
    rreg(0, 7, v); chk("R11 unlisted reads 0", 32'(v), 32'h00);
    rreg(0, 3, v); chk("R11 unlisted reads 0", 32'(v), 32'h00);

    // R4: selective channel reset
    wreg(0, 4, 8'hC1); wreg(1, 4, 8'hC1);
    wreg(1, 9, 8'h40);
    chk("R4 ch0 reset", 32'(mult[6:0]), 32'd1);
    chk("R4 ch1 kept", 32'(mult[13:7]), 32'd64);
    wreg(0, 4, 8'hC1);
    wreg(0, 9, 8'h80);
    chk("R4 ch1 reset", 32'(mult[13:7]), 32'd1);
    chk("R4 ch0 kept", 32'(par_en[0]), 32'd1);
    wreg(1, 4, 8'hC1);
    wreg(0, 9, 8'h00);
    chk("R4 field 00 no reset", 32'({par_en[1], par_en[0]}), 32'd3);
    wreg(1, 9, 8'hC0);
    chk("R4 both reset", 32'({par_en[1], par_en[0]}), 32'd0);
    rreg(0, 12, v); chk("R4 tc cleared", 32'(v), 32'h00);

    // R10: receive path
    @(negedge clk); rx_byte = 16'hA500; rx_load = 2'b10;
    @(negedge clk); rx_load = 2'b00;
    rreg(1, 0, v); chk("R10 rx available", 32'(v), 32'h45);
    rreg(0, 0, v); chk("R10 other channel", 32'(v), 32'h44);
    acc(da(1), 1'b0, 8'h00); chk("R10 rx byte", 32'(rd_data), 32'hA5);
    rreg(1, 0, v); chk("R10 rx cleared", 32'(v), 32'h44);

    // R9: transmit path
    @(negedge clk); tx_taken = 2'b01;
    @(negedge clk); tx_taken = 2'b00;
    rreg(0, 0, v); chk("R9 taken clears status", 32'(v), 32'h40);
    rreg(0, 1, v); chk("R9 taken clears special", 32'(v), 32'h06);
    @(negedge clk); addr = da(0); wr = 1'b1; wdata = 8'h3C;
    #1 chk("R9 no strobe when disabled", 32'(tx_strobe), 32'd0);
    @(negedge clk); wr = 1'b0;
    rreg(0, 0, v); chk("R9 data write sets status", 32'(v), 32'h44);
    rreg(0, 1, v); chk("R9 data write sets special", 32'(v), 32'h07);
    wreg(0, 5, 8'h08);
    @(negedge clk); addr = da(0); wr = 1'b1; wdata = 8'h3C; tx_taken = 2'b01;
    #1 chk("R9 strobe", 32'(tx_strobe), 32'd1);
    chk("R9 byte", 32'(tx_byte), 32'h3C);
    @(negedge clk); wr = 1'b0; tx_taken = 2'b00;
    rreg(0, 0, v); chk("R9 write wins over taken", 32'(v), 32'h44);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule